// File: doc/BRIEF.md
# Index-Mode Remap Configuration Writer

This block carries out the setup step for index-driven element reordering. It takes one decoded setup instruction: an index register number, a 5-bit operand mask, an off-by-one dimension, an index element width, a transpose flag, a mask-interpretation flag and a skip flag. From these it computes new contents for four 32-bit shape registers and for the remap portion of a 64-bit state register. The remap portion holds five 2-bit shape selectors (three source operands and two destination operands), five enable bits and a persistence bit.

Two mask interpretations are supported. In the bulk interpretation every shape and the whole remap portion are rebuilt. Each marked operand receives the next shape in turn, wrapping after shape 3. In the targeted interpretation the mask is split into an operand code and a shape number, and only that one shape, selector and enable bit change. The block holds the register values it produces. It presents them together with per-register write strobes, and with a bit-level strobe for the state word, one cycle after the instruction is accepted.

Top module: `remap_cfg_writer`

## Requirements
- R1: After synchronous reset all shape words and the state word read zero and every strobe is low.
- R2: All outputs produced by an instruction appear on the first clock edge after the edge that samples `instr_vld` high. Strobes are high for that one cycle only and are low in every cycle that did not follow an accepted instruction.
- R3: A written shape word has bits 31:30 = 00, bits 29:28 = `ew`, bits 27:24 = 0, bit 23 = `sk`, bits 22:21 = 0, and bits 20:18 = 110 when `yx`=0 or 111 when `yx`=1.
- R4: Shape bits 17:12 hold the index register number halved, which is `{idx_reg,1'b0}` because the register number is `idx_reg` times four.
- R5: Shape bits 5:0 hold `{1'b0,dim}`. Bits 11:6 hold CEIL(`maxvl`/(`dim`+1))-1 when `yx`=1 and `sk`=0, saturated to 63 and held at 0 when the quotient is 0. In all other cases they hold 0.
- R6: With `mm`=0, all four shapes are strobed. The set mask bits are visited from bit 0 upward, and each one is given the next shape number starting at 0 and wrapping modulo 4. Every shape that is handed out is loaded with the new word and every other shape is cleared.
- R7: State layout: the selector of operand k (0..4 = src A, src B, src C, dst T, dst S) sits at bits 33+2k:32+2k, its enable at bit 42+k, and persistence at bit 62. With `mm`=0 the enables equal `rmask`, unmarked selectors are 0, persistence is 0, and the state strobe covers all 16 of these bits.
- R8: With `mm`=0 and `rmask`=11111, operands 0 and 4 both select shape 0.
- R9: With `mm`=1, operand code `rmask[4:2]` (0..4) and shape `rmask[1:0]` are used. Only that shape, that selector and that enable (set to 1) are written, and all other shape and state bits keep their values.
- R10: With `mm`=1 and a valid operand code, persistence is set to 1.
- R11: With `mm`=1 and operand code 5, 6 or 7, no strobe rises and no shape or state bit changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_vld | input | 1 | Setup instruction present this cycle |
| idx_reg | input | 5 | Index register number divided by four |
| rmask | input | 5 | Operand mask or operand/shape code |
| dim | input | 5 | First dimension minus one |
| ew | input | 2 | Element width code of the indices |
| yx | input | 1 | Transposed 2D ordering |
| mm | input | 1 | Mask interpretation: 0 bulk, 1 targeted |
| sk | input | 1 | Dimension skip flag |
| maxvl | input | 7 | Maximum vector length for the second dimension |
| shape_q | output | 128 | Shape words, shape k at bits 32k+31:32k |
| shape_we | output | 4 | Per-shape write strobe |
| state_q | output | 64 | State word, remap portion only |
| state_wmask | output | 64 | Bit-level write strobe for the state word |

## Verification
Two effects can fall on the same operation and must not disturb each other. The first is the modulo-4 wrap in bulk allocation, which hands shape 0 to both the first and the fifth operand in one write. The second is a targeted write issued in the very next cycle after a bulk write, which has to merge into freshly rebuilt state. The bench provokes the first with an all-ones mask and the second by driving a bulk and a targeted instruction on consecutive cycles. A scoreboard model predicts each result, and the bench compares every shape, the state word and the strobes one cycle after each instruction.

// File: rtl/remap_cfg_pkg.sv
package remap_cfg_pkg;

    localparam int NUM_SHAPES = 4;
    localparam int NUM_OPS    = 5;
    localparam int SEL_W      = $clog2(NUM_SHAPES);
    localparam int SHAPE_W    = 32;
    localparam int STATE_W    = 64;
    localparam int MASK_W     = NUM_OPS;
    localparam int DIM_W      = 5;
    localparam int DSZ_W      = 6;
    localparam int MAXVL_W    = 7;
    localparam int SEL_BASE   = 32;
    localparam int EN_BASE    = 42;
    localparam int PERS_BIT   = 62;
    localparam int OPC_W      = 3;

    typedef enum logic [OPC_W-1:0] {
        OP_SRC_A = 3'd0,
        OP_SRC_B = 3'd1,
        OP_SRC_C = 3'd2,
        OP_DST_T = 3'd3,
        OP_DST_S = 3'd4
    } op_code_e;

    typedef struct packed {
        logic [1:0]       mode;
        logic [1:0]       elw;
        logic [3:0]       offs;
        logic             skip;
        logic [1:0]       inv;
        logic [2:0]       perm;
        logic [DSZ_W-1:0] gpr;
        logic [DSZ_W-1:0] ydim;
        logic [DSZ_W-1:0] xdim;
    } shape_word_t;

    typedef struct packed {
        logic                            persist;
        logic [NUM_OPS-1:0]              en;
        logic [NUM_OPS-1:0][SEL_W-1:0]   sel;
    } remap_area_t;

    typedef struct packed {
        logic [NUM_SHAPES-1:0] we;
        logic [NUM_SHAPES-1:0] load;
    } shape_ctl_t;

    function automatic logic [STATE_W-1:0] pack_area(input remap_area_t a);
        logic [STATE_W-1:0] s;
        s = '0;
        for (int k = 0; k < NUM_OPS; k++) begin
            s[SEL_BASE + SEL_W*k +: SEL_W] = a.sel[k];
            s[EN_BASE + k]                 = a.en[k];
        end
        s[PERS_BIT] = a.persist;
        return s;
    endfunction

    function automatic logic [DSZ_W-1:0] sat_minus_one(input logic [MAXVL_W:0] q);
        logic [DSZ_W-1:0] r;
        if (q == '0)
            r = '0;
        else if (q > (MAXVL_W+1)'(1 << DSZ_W))
            r = '1;
        else
            r = DSZ_W'(q - 1'b1);
        return r;
    endfunction

endpackage

// File: rtl/remap_ydim_calc.sv
module remap_ydim_calc
    import remap_cfg_pkg::*;
(
    input  logic [DIM_W-1:0]   dim,
    input  logic [MAXVL_W-1:0] maxvl,
    input  logic               yx,
    input  logic               sk,
    output logic [DSZ_W-1:0]   ydim
);
    localparam int SUM_W = MAXVL_W + 1;

    logic [SUM_W-1:0] divisor;
    logic [SUM_W-1:0] dividend;
    logic [SUM_W-1:0] quot;

    always_comb begin
        divisor  = SUM_W'(dim) + 1'b1;
        dividend = SUM_W'(maxvl) + divisor - 1'b1;
        quot     = dividend / divisor;
        if (yx && !sk)
            ydim = sat_minus_one(quot);
        else
            ydim = '0;
    end
endmodule

// File: rtl/remap_shape_gen.sv
module remap_shape_gen
    import remap_cfg_pkg::*;
(
    input  logic [4:0]        idx_reg,
    input  logic [DIM_W-1:0]  dim,
    input  logic [1:0]        ew,
    input  logic              yx,
    input  logic              sk,
    input  logic [DSZ_W-1:0]  ydim,
    output shape_word_t       word
);
    localparam logic [2:0] PERM_XY = 3'b110;
    localparam logic [2:0] PERM_YX = 3'b111;

    always_comb begin
        word.mode = 2'b00;
        word.elw  = ew;
        word.offs = 4'd0;
        word.skip = sk;
        word.inv  = 2'b00;
        word.perm = yx ? PERM_YX : PERM_XY;
        word.gpr  = {idx_reg, 1'b0};
        word.ydim = ydim;
        word.xdim = {1'b0, dim};
    end
endmodule

// File: rtl/remap_mask_alloc.sv
module remap_mask_alloc
    import remap_cfg_pkg::*;
(
    input  logic [MASK_W-1:0] rmask,
    input  logic              mm,
    input  remap_area_t       cur,
    output remap_area_t       nxt,
    output remap_area_t       wmask,
    output shape_ctl_t        sctl
);
    logic [SEL_W-1:0] next_shape;
    logic [OPC_W-1:0] opc;
    logic [SEL_W-1:0] tgt;
    logic             opc_ok;

    assign opc    = rmask[MASK_W-1 -: OPC_W];
    assign tgt    = rmask[SEL_W-1:0];
    assign opc_ok = (opc <= OPC_W'(OP_DST_S));

    always_comb begin
        nxt        = cur;
        wmask      = '0;
        sctl       = '0;
        next_shape = '0;
        if (!mm) begin
            nxt          = '0;
            wmask.sel    = '1;
            wmask.en     = '1;
            wmask.persist = 1'b1;
            sctl.we      = '1;
            for (int b = 0; b < NUM_OPS; b++) begin
                if (rmask[b]) begin
                    nxt.sel[b]            = next_shape;
                    sctl.load[next_shape] = 1'b1;
                    next_shape            = next_shape + 1'b1;
                end
            end
            nxt.en      = rmask;
            nxt.persist = 1'b0;
        end else if (opc_ok) begin
            nxt.sel[opc]   = tgt;
            nxt.en[opc]    = 1'b1;
            nxt.persist    = 1'b1;
            wmask.sel[opc] = '1;
            wmask.en[opc]  = 1'b1;
            wmask.persist  = 1'b1;
            sctl.we[tgt]   = 1'b1;
            sctl.load[tgt] = 1'b1;
        end
    end
endmodule

// File: rtl/remap_cfg_writer.sv
module remap_cfg_writer
    import remap_cfg_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          instr_vld,
    input  logic [4:0]                    idx_reg,
    input  logic [MASK_W-1:0]             rmask,
    input  logic [DIM_W-1:0]              dim,
    input  logic [1:0]                    ew,
    input  logic                          yx,
    input  logic                          mm,
    input  logic                          sk,
    input  logic [MAXVL_W-1:0]            maxvl,
    output logic [NUM_SHAPES*SHAPE_W-1:0] shape_q,
    output logic [NUM_SHAPES-1:0]         shape_we,
    output logic [STATE_W-1:0]            state_q,
    output logic [STATE_W-1:0]            state_wmask
);
    logic [DSZ_W-1:0]     ydim;
    shape_word_t          word;
    remap_area_t          area_q;
    remap_area_t          area_nxt;
    remap_area_t          area_wm;
    shape_ctl_t           sctl;
    logic [SHAPE_W-1:0]   shape_r [NUM_SHAPES];
    logic [NUM_SHAPES-1:0] we_r;
    logic [STATE_W-1:0]   wm_r;

    remap_ydim_calc u_ydim (
        .dim   (dim),
        .maxvl (maxvl),
        .yx    (yx),
        .sk    (sk),
        .ydim  (ydim)
    );

    remap_shape_gen u_gen (
        .idx_reg (idx_reg),
        .dim     (dim),
        .ew      (ew),
        .yx      (yx),
        .sk      (sk),
        .ydim    (ydim),
        .word    (word)
    );

    remap_mask_alloc u_alloc (
        .rmask (rmask),
        .mm    (mm),
        .cur   (area_q),
        .nxt   (area_nxt),
        .wmask (area_wm),
        .sctl  (sctl)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            area_q <= '0;
            we_r   <= '0;
            wm_r   <= '0;
        end else begin
            we_r <= instr_vld ? sctl.we : '0;
            wm_r <= instr_vld ? pack_area(area_wm) : '0;
            if (instr_vld)
                area_q <= area_nxt;
        end
    end

    generate
        for (genvar k = 0; k < NUM_SHAPES; k++) begin : g_shape
            always_ff @(posedge clk) begin
                if (rst)
                    shape_r[k] <= '0;
                else if (instr_vld && sctl.we[k])
                    shape_r[k] <= sctl.load[k] ? SHAPE_W'(word) : '0;
            end
            assign shape_q[SHAPE_W*k +: SHAPE_W] = shape_r[k];
        end
    endgenerate

    assign shape_we    = we_r;
    assign state_q     = pack_area(area_q);
    assign state_wmask = wm_r;
endmodule

// File: rtl/remap_cfg_writer_chk.sv
module remap_cfg_writer_chk
    import remap_cfg_pkg::*;
(
    input logic                  clk,
    input logic                  rst,
    input logic                  instr_vld,
    input logic                  mm,
    input logic [MASK_W-1:0]     rmask,
    input logic [NUM_SHAPES-1:0] shape_we,
    input logic [STATE_W-1:0]    state_q,
    input logic [STATE_W-1:0]    state_wmask
);
    // R2
    idle_no_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(instr_vld) |-> (shape_we == '0 && state_wmask == '0));

    // R6
    bulk_all_shapes_chk: assert property (@(posedge clk) disable iff (rst)
        $past(instr_vld && !mm) |-> shape_we == '1);

    // R7
    bulk_enable_copy_chk: assert property (@(posedge clk) disable iff (rst)
        $past(instr_vld && !mm) |-> (state_q[EN_BASE +: NUM_OPS] == $past(rmask) && !state_q[PERS_BIT]));

    // R9
    targeted_single_chk: assert property (@(posedge clk) disable iff (rst)
        $past(instr_vld && mm) |-> $onehot0(shape_we));

    // R10
    targeted_persist_chk: assert property (@(posedge clk) disable iff (rst)
        $past(instr_vld && mm && rmask[MASK_W-1 -: OPC_W] <= 3'd4) |-> state_q[PERS_BIT]);

    // R11
    reserved_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $past(instr_vld && mm && rmask[MASK_W-1 -: OPC_W] > 3'd4) |->
            (shape_we == '0 && state_wmask == '0 && $stable(state_q)));
endmodule

bind remap_cfg_writer remap_cfg_writer_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .instr_vld   (instr_vld),
    .mm          (mm),
    .rmask       (rmask),
    .shape_we    (shape_we),
    .state_q     (state_q),
    .state_wmask (state_wmask)
);

// File: tb/tb_remap_cfg_writer.sv
module tb_remap_cfg_writer;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         instr_vld = 1'b0;
    logic [4:0]   idx_reg = '0;
    logic [4:0]   rmask = '0;
    logic [4:0]   dim = '0;
    logic [1:0]   ew = '0;
    logic         yx = 1'b0;
    logic         mm = 1'b0;
    logic         sk = 1'b0;
    logic [6:0]   maxvl = '0;
    logic [127:0] shape_q;
    logic [3:0]   shape_we;
    logic [63:0]  state_q;
    logic [63:0]  state_wmask;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [127:0] shapes;
        logic [3:0]   we;
        logic [63:0]  state;
        logic [63:0]  wm;
        string        tag;
    } exp_t;

    exp_t         q[$];
    logic [31:0]  m_shape [4];
    logic [63:0]  m_state = '0;

    always #2 clk = ~clk;

    remap_cfg_writer dut (
        .clk(clk), .rst(rst), .instr_vld(instr_vld), .idx_reg(idx_reg),
        .rmask(rmask), .dim(dim), .ew(ew), .yx(yx), .mm(mm), .sk(sk),
        .maxvl(maxvl), .shape_q(shape_q), .shape_we(shape_we),
        .state_q(state_q), .state_wmask(state_wmask)
    );

    task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] model_word(input logic [4:0] g, input logic [4:0] d,
            input logic [1:0] e, input logic y, input logic s, input logic [6:0] mv);
        int dv;
        int cq;
        logic [5:0] yd;
        dv = int'(d) + 1;
        cq = (int'(mv) + dv - 1) / dv;
        if (y && !s && cq > 0) yd = (cq - 1 > 63) ? 6'd63 : 6'(cq - 1);
        else yd = 6'd0;
        return {2'b00, e, 4'b0000, s, 2'b00, (y ? 3'b111 : 3'b110), g, 1'b0, yd, 1'b0, d};
    endfunction

    task automatic issue(input string tag, input logic [4:0] g, input logic [4:0] m,
            input logic [4:0] d, input logic [1:0] e, input logic y, input logic mmode,
            input logic s, input logic [6:0] mv);
        exp_t x;
        logic [31:0] w;
        logic [1:0]  nxt;
        int          opc;
        @(negedge clk);
        idx_reg = g; rmask = m; dim = d; ew = e; yx = y; mm = mmode; sk = s; maxvl = mv;
        instr_vld = 1'b1;
        w = model_word(g, d, e, y, s, mv);
        x.we = '0; x.wm = '0; x.tag = tag;
        if (!mmode) begin
            for (int k = 0; k < 4; k++) m_shape[k] = '0;
            m_state = '0;
            nxt = '0;
            for (int b = 0; b < 5; b++) begin
                if (m[b]) begin
                    m_shape[nxt] = w;
                    m_state[32 + 2*b +: 2] = nxt;
                    nxt = nxt + 1'b1;
                end
            end
            m_state[46:42] = m;
            x.we = 4'hF;
            x.wm = 64'h0;
            x.wm[46:32] = '1;
            x.wm[62] = 1'b1;
        end else begin
            opc = int'(m[4:2]);
            if (opc <= 4) begin
                m_shape[m[1:0]] = w;
                m_state[32 + 2*opc +: 2] = m[1:0];
                m_state[42 + opc] = 1'b1;
                m_state[62] = 1'b1;
                x.we[m[1:0]] = 1'b1;
                x.wm[32 + 2*opc +: 2] = 2'b11;
                x.wm[42 + opc] = 1'b1;
                x.wm[62] = 1'b1;
            end
        end
        x.shapes = {m_shape[3], m_shape[2], m_shape[1], m_shape[0]};
        x.state  = m_state;
        q.push_back(x);
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        instr_vld = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    // scoreboard monitor
    initial begin
        bit fire;
        exp_t x;
        forever begin
            @(posedge clk);
            fire = (!rst && instr_vld);
            @(negedge clk);
            if (fire) begin
                x = q.pop_front();
                check({x.tag, " shapes"}, shape_q, x.shapes);
                check({x.tag, " shape_we"}, 128'(shape_we), 128'(x.we));
                check({x.tag, " state"}, 128'(state_q), 128'(x.state));
                check({x.tag, " state_wmask"}, 128'(state_wmask), 128'(x.wm));
            end else if (!rst) begin
                check("R2 idle strobes", 128'({shape_we, state_wmask}), 128'(0));
            end
        end
    end

    initial begin
        for (int k = 0; k < 4; k++) m_shape[k] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset shapes", shape_q, '0);
        check("R1 reset state", 128'(state_q), '0);
        check("R1 reset strobes", 128'({shape_we, state_wmask}), '0);

        // R3 R4 R6 R7: two operands, plain ordering
        issue("R6 R3 R4 mask00110", 5'd3, 5'b00110, 5'd7, 2'd1, 1'b0, 1'b0, 1'b0, 7'd40);
        idle(1);
        // R6 R7: first and last operand
        issue("R7 mask10001", 5'd9, 5'b10001, 5'd2, 2'd2, 1'b0, 1'b0, 1'b1, 7'd12);
        idle(1);
        // R8 R5: wrap, transposed ceil(10/3)=4 -> 3
        issue("R8 R5 mask11111", 5'd31, 5'b11111, 5'd2, 2'd3, 1'b1, 1'b0, 1'b0, 7'd10);
        idle(1);
        // R9 R10: targeted mo0 shape 2 merges into prior state
        issue("R9 R10 op3 shape2", 5'd5, 5'b01110, 5'd4, 2'd0, 1'b1, 1'b1, 1'b1, 7'd20);
        idle(1);
        issue("R9 op4 shape3", 5'd6, 5'b10011, 5'd1, 2'd1, 1'b0, 1'b1, 1'b0, 7'd20);
        idle(1);
        // R11: reserved operand codes
        issue("R11 op7", 5'd1, 5'b11101, 5'd1, 2'd1, 1'b1, 1'b1, 1'b0, 7'd9);
        idle(1);
        issue("R11 op5", 5'd2, 5'b10110, 5'd3, 2'd2, 1'b0, 1'b1, 1'b0, 7'd9);
        idle(1);
        // R5 saturation: ceil(127/1)=127 -> 63
        issue("R5 saturate", 5'd4, 5'b00001, 5'd0, 2'd0, 1'b1, 1'b0, 1'b0, 7'd127);
        idle(1);
        // R5 skip forces zero, and maxvl zero
        issue("R5 skip", 5'd4, 5'b00011, 5'd5, 2'd0, 1'b1, 1'b0, 1'b1, 7'd100);
        idle(1);
        issue("R5 maxvl0", 5'd4, 5'b00100, 5'd5, 2'd0, 1'b1, 1'b0, 1'b0, 7'd0);
        idle(1);
        // R6: empty mask clears everything
        issue("R6 empty mask", 5'd8, 5'b00000, 5'd5, 2'd0, 1'b0, 1'b0, 1'b0, 7'd8);
        idle(1);
        // back-to-back bulk then targeted (R6 R9)
        issue("R6 b2b bulk", 5'd10, 5'b01011, 5'd3, 2'd1, 1'b1, 1'b0, 1'b0, 7'd17);
        issue("R9 b2b targeted", 5'd12, 5'b00101, 5'd6, 2'd2, 1'b0, 1'b1, 1'b0, 7'd17);
        issue("R10 b2b targeted2", 5'd13, 5'b01000, 5'd9, 2'd3, 1'b1, 1'b1, 1'b1, 7'd30);
        idle(3);
        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 5000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule